// File: doc/BRIEF.md
# Flagged Word FIFO with Read Rewind

This block is a single-clock first-in first-out buffer for 9-bit parallel words that feed a downstream serializer. A producer strobes words in; the serializer strobes one word out at the start of each serial word it sends. The depth is a power-of-two parameter, 2048 by default. The block keeps an occupancy count. From that count it derives four active-low status flags: empty, full, more-than-half, and a combined edge flag. The edge flag is low whenever the buffer is nearly empty or nearly full.

Writes and reads are independent and may happen in the same cycle. A write into a full buffer and a read from an empty buffer are both dropped, so the pointers can never overrun. A synchronous reset clears both pointers. A rewind command returns only the read pointer to location zero, so the serializer can replay everything written since reset without any help from the producer. A popped word appears on the read-data port one clock after the accepted read strobe, and it holds there until the next accepted read.

Top module: `flagfifo`

## Requirements
- R1: While `rstN` is low at a clock edge, both pointers and the count go to zero and `rdData` goes to zero. After that edge `emptyN`=0, `edgeN`=0, `fullN`=1 and `halfN`=1.
- R2: A write strobe while `fullN`=0 is dropped. The write pointer does not move, and no stored word changes.
- R3: A read strobe while `emptyN`=0 is dropped. `rdData` keeps its value and the read pointer holds.
- R4: `edgeN` is 0 when the count is below DEPTH/8 or above DEPTH-DEPTH/8, and 1 otherwise. For DEPTH=2048 it is 0 at 0–255 and at 1793–2048.
- R5: `halfN` is 0 exactly when the count exceeds DEPTH/2.
- R6: `fullN` is 0 only at count DEPTH, and `emptyN` is 0 only at count 0.
- R7: Words leave in the order they were accepted. Each word is on `rdData` in the cycle after its accepted read strobe.
- R8: A read and a write in the same cycle, when the buffer is neither empty nor full, both take effect and leave the count unchanged.
- R9: A read and a write in the same cycle while full perform only the read. While empty, they perform only the write, and `rdData` is unchanged.
- R10: `rewindReq` sets the read pointer to zero and leaves the write pointer alone. It blocks any read in that cycle. The count becomes the number of words written since reset, and all flags reflect that count on the next cycle. Replay is valid while at most DEPTH words have been written since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | 9 | Word to store |
| rdEn | input | 1 | Read strobe from the serializer |
| rewindReq | input | 1 | Return the read pointer to location zero |
| rdData | output | 9 | Last word popped |
| emptyN | output | 1 | Low when the count is zero |
| fullN | output | 1 | Low when the count equals DEPTH |
| halfN | output | 1 | Low when the count exceeds DEPTH/2 |
| edgeN | output | 1 | Low in the bottom or top eighth of occupancy |

## Verification
The bench fills the full default depth and then drains it. It compares every flag against a model count on every cycle, so an off-by-one threshold, such as an edge flag that turns at 1792 instead of 1793, is caught at the exact boundary. Stray strobes at full and at empty, including combined read-and-write strobes, are checked in both directions. A design that let the write through at full would overwrite the oldest word, which the drain would expose. A design that popped at empty would change `rdData`, or later hand out stale data. The rewind test reads part of the contents, rewinds, and expects the whole written sequence again. A design that also cleared the write side, or left the count stale, would report wrong flags or replay the wrong words.

// File: rtl/flagfifo_pkg.sv
`timescale 1ns/1ps
package flagfifo_pkg;
  // Strobes from the control to the storage datapath
  typedef struct packed {
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/flagfifo_ctrl.sv
`timescale 1ns/1ps
module flagfifo_ctrl
  import flagfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic rdEn,
  input  logic rewindReq,
  output fifoStrobe_t strobe,
  output logic [$clog2(DEPTH)-1:0] wrAddr,
  output logic [$clog2(DEPTH)-1:0] rdAddr,
  output logic emptyN,
  output logic fullN,
  output logic halfN,
  output logic edgeN
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0] LOW_MARK = CW'(DEPTH / 8);
  localparam logic [CW-1:0] HIGH_MARK = CW'(DEPTH - DEPTH / 8);
  localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);

  logic [CW-1:0] wrPtr;   // extra bit tracks words written since reset
  logic [AW-1:0] rdPtr;
  logic [CW-1:0] count;
  logic isEmpty, isFull;

  assign isEmpty = (count == '0);
  assign isFull  = (count == DEPTH_C);

  // Full blocks the write; empty or rewind blocks the read
  assign strobe.push = wrEn && !isFull;
  assign strobe.pop  = rdEn && !isEmpty && !rewindReq;

  assign wrAddr = wrPtr[AW-1:0];
  assign rdAddr = rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + CW'(1);
      if (rewindReq) rdPtr <= '0;
      else if (strobe.pop) rdPtr <= rdPtr + AW'(1);
      if (rewindReq) count <= wrPtr + CW'(strobe.push);
      else count <= count + CW'(strobe.push) - CW'(strobe.pop);
    end
  end

  // Flag decode from the occupancy register
  always_comb begin
    emptyN = !isEmpty;
    fullN  = !isFull;
    halfN  = !(count > HALF_MARK);
    edgeN  = !((count < LOW_MARK) || (count > HIGH_MARK));
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !fullN) |=> $stable(wrPtr));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !emptyN && !rewindReq) |=> $stable(rdPtr));
  p_full_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    !fullN |-> (!halfN && !edgeN && emptyN));
  p_empty_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    !emptyN |-> (!edgeN && halfN && fullN));
  p_balanced_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdEn && emptyN && fullN && !rewindReq) |=> $stable(count));
  p_rewind_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rewindReq && !wrEn) |=> (rdPtr == '0 && $stable(wrPtr)));
endmodule

// File: rtl/flagfifo_store.sv
`timescale 1ns/1ps
module flagfifo_store
  import flagfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned WIDTH = 9
) (
  input  logic clk,
  input  logic rstN,
  input  fifoStrobe_t strobe,
  input  logic [$clog2(DEPTH)-1:0] wrAddr,
  input  logic [$clog2(DEPTH)-1:0] rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (strobe.pop) rdData <= mem[rdAddr];
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pop |=> $stable(rdData));
endmodule

// File: rtl/flagfifo.sv
`timescale 1ns/1ps
module flagfifo
  import flagfifo_pkg::*;
#(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned WIDTH = 9
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic rdEn,
  input  logic rewindReq,
  output logic [WIDTH-1:0] rdData,
  output logic emptyN,
  output logic fullN,
  output logic halfN,
  output logic edgeN
);
  localparam int AW = $clog2(DEPTH);

  fifoStrobe_t strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  flagfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rewindReq(rewindReq),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN), .edgeN(edgeN)
  );

  flagfifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/tb_flagfifo.sv
`timescale 1ns/1ps
module tb_flagfifo;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, rewindReq = 1'b0;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic emptyN, fullN, halfN, edgeN;

  int nChecks = 0, nErr = 0;
  int mCount = 0;
  logic [8:0] expQ[$];
  logic [8:0] hist[$];
  logic [8:0] lastRd = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flagfifo dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rewindReq(rewindReq), .rdData(rdData), .emptyN(emptyN), .fullN(fullN),
    .halfN(halfN), .edgeN(edgeN)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor side: compare ports against the model after each edge
  task automatic checkAll();
    chk("R6 emptyN", int'(emptyN), int'(mCount != 0));
    chk("R6 fullN", int'(fullN), int'(mCount != DEPTH));
    chk("R5 halfN", int'(halfN), int'(!(mCount > DEPTH / 2)));
    chk("R4 edgeN", int'(edgeN), int'(!(mCount < DEPTH / 8 || mCount > DEPTH - DEPTH / 8)));
    chk("R7 rdData", int'(rdData), int'(lastRd));
  endtask

  // Driver: apply strobes for one cycle and update the scoreboard
  task automatic step(input bit w, input logic [8:0] d, input bit r, input bit rt);
    bit accW, accR;
    wrEn = w; wrData = d; rdEn = r; rewindReq = rt;
    @(posedge clk);
    accW = w && (mCount < DEPTH);
    accR = r && (mCount > 0) && !rt;
    if (accW) begin expQ.push_back(d); hist.push_back(d); end
    if (accR) lastRd = expQ.pop_front();
    if (rt) begin expQ = hist; mCount = hist.size(); end
    else mCount = mCount + int'(accW) - int'(accR);
    @(negedge clk);
    wrEn = 0; rdEn = 0; rewindReq = 0;
    checkAll();
  endtask

  task automatic doReset();
    rstN = 0; wrEn = 0; rdEn = 0; rewindReq = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    mCount = 0; expQ.delete(); hist.delete(); lastRd = '0;
    // R1 reset state
    chk("R1 emptyN", int'(emptyN), 0);
    chk("R1 edgeN", int'(edgeN), 0);
    chk("R1 fullN", int'(fullN), 1);
    chk("R1 halfN", int'(halfN), 1);
    chk("R1 rdData", int'(rdData), 0);
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R3: read while empty is dropped
    step(0, 9'h0, 1, 0);
    chk("R3 rdData held", int'(rdData), 0);
    // R9: write+read while empty -> write only
    step(1, 9'h055, 1, 0);
    chk("R9 empty rw count", int'(emptyN), 1);
    chk("R9 empty rw rdData", int'(rdData), 0);
    step(0, 9'h0, 1, 0);
    chk("R7 first word", int'(rdData), 9'h055);

    // Fill to full; flags checked every cycle (R4 R5 R6)
    for (int i = 0; i < DEPTH; i++) step(1, 9'((i * 7 + 3) % 512), 0, 0);
    chk("R6 full at depth", int'(fullN), 0);
    // R2: write at full ignored
    step(1, 9'h1FF, 0, 0);
    chk("R2 still full", int'(fullN), 0);
    // R9: write+read at full -> read only
    step(1, 9'h1AA, 1, 0);
    chk("R9 full rw not full", int'(fullN), 1);
    // Drain; data order proves nothing was overwritten (R2 R7)
    while (mCount > 0) step(0, 9'h0, 1, 0);
    chk("R6 empty after drain", int'(emptyN), 0);

    // R8: balanced traffic
    for (int i = 0; i < 5; i++) step(1, 9'(100 + i), 0, 0);
    for (int i = 0; i < 20; i++) begin
      step(1, 9'(200 + i), 1, 0);
      chk("R8 count steady", mCount, 5);
    end
    while (mCount > 0) step(0, 9'h0, 1, 0);

    // R10: rewind replays from location zero
    doReset();
    for (int i = 0; i < 300; i++) step(1, 9'(i + 17), 0, 0);
    for (int i = 0; i < 100; i++) step(0, 9'h0, 1, 0);
    step(0, 9'h0, 1, 1);
    chk("R10 edge valid after rewind", int'(edgeN), 1);
    chk("R10 rdData unchanged", int'(rdData), 116);
    step(0, 9'h0, 1, 0);
    chk("R10 replay first", int'(rdData), 17);
    while (mCount > 0) step(0, 9'h0, 1, 0);
    chk("R10 replay last", int'(rdData), 316);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule